// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Parking

This block decides which of several bus masters owns one slave port of a multi-master AHB-style crossbar. Every master presents a port-select flag, a transfer type, a burst type, a lock flag and a flag saying it still has an unfinished access at some other slave port. The block holds the ownership state and forwards only the owner's transfer type to the slave bus. It stalls every other master that is trying to use the port, and it completes IDLE transfers itself.

Ownership changes only at an arbitration point, which is a cycle with slave hready high in which the owner is not inside a protected transfer. Locked transfers and fixed-length bursts are protected. Undefined-length incrementing bursts are protected only when the owner's retain bit is set. At an arbitration point the eligible master with the smallest priority value wins. When nothing is requested, the port can be parked on a chosen master, kept on the last owner, or released into low-power park, in which the arbiter itself owns the bus.

Top module: `xbar_slave_arbiter`

## Requirements
- R1: A master with `sel_i` high and a non-IDLE `htrans_i` that does not hold the grant sees `mready_o` low. The granted master sees `mready_o` equal to `hready_i`.
- R2: A master whose `pend_i` bit is high is never granted while it is requesting, whatever its priority.
- R3: An owner keeps the grant at arbitration points until it issues IDLE or drops `sel_i`, unless R4 applies.
- R4: At an arbitration point the eligible requester with the smallest `prio_i` value wins. On equal values the current owner stays, and among non-owners the lower index wins. With `hready_i` low the grant does not change.
- R5: While the owner drives `hlock_i` high on a non-IDLE transfer, or is inside a fixed-length burst (`hburst_i` 3'b010..3'b111, lengths 4, 8 and 16 for bits [2:1] = 01, 10 and 11), the grant holds. Arbitration resumes on the burst's last beat.
- R6: For an undefined-length burst (`hburst_i` = 3'b001, INCR) the grant holds when the owner's `aulb_i` bit is 1. When that bit is 0, a higher-priority master takes the port on any beat.
- R7: A master issuing IDLE (2'b00) that does not hold the grant gets `mready_o` high. An owner's IDLE is driven onto the slave as IDLE.
- R8: When no master requests the port, `htrans_o` is IDLE (2'b00), even while a parked master holds the grant.
- R9: With no requester and `park_mode_i` = 2'b00 the grant moves to master `park_id_i`. With `park_mode_i` = 2'b01 it stays on the last owner.
- R10: With no requester and `park_mode_i[1]` = 1 (low-power park) the grant clears and `hmaster_o` reads 0.
- R11: `grant_o` is one-hot or zero. `hmaster_o` is the owner's index plus one, and 0 when no master holds the grant.
- R12: When a master regains the port while driving SEQ, its first forwarded beat appears on `htrans_o` as NONSEQ (2'b10).
- R13: After reset no master holds the grant, `hmaster_o` is 0 and `htrans_o` is IDLE.

Transfer codes: IDLE 2'b00, BUSY 2'b01, NONSEQ 2'b10, SEQ 2'b11. `hburst_i` 3'b000 is SINGLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | NM | Master addresses this slave port |
| htrans_i | input | NM x 2 | Transfer type per master |
| hburst_i | input | NM x 3 | Burst type per master |
| hlock_i | input | NM | Locked transfer per master |
| pend_i | input | NM | Master has an unfinished access at another slave port |
| prio_i | input | NM x PW | Priority per master, smaller value wins |
| aulb_i | input | NM | Keep port for whole undefined-length burst |
| park_mode_i | input | 2 | 00 park on id, 01 park on last owner, 1x low-power park |
| park_id_i | input | IW | Master index used by fixed park |
| hready_i | input | 1 | Slave bus ready |
| grant_o | output | NM | One-hot owner of the slave port |
| hmaster_o | output | HW | Owner index plus one, 0 when the arbiter owns the bus |
| htrans_o | output | 2 | Transfer type driven onto the slave bus |
| mready_o | output | NM | Ready returned to each master |

## Verification
A wrong owner register shows up at once at the ports. In the following cycle `grant_o`, `hmaster_o` and the stalled master's `mready_o` all disagree with the priority rules. A burst beat counter that is off by one does not show while the burst runs. It shows as a grant change one beat early or one beat late around the last SEQ, so the bench samples the grant on each beat of a four-beat burst. A stuck re-grant flag shows as SEQ rather than NONSEQ on `htrans_o` in the first cycle after a preempted master regains the port.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00, TR_BUSY = 2'b01, TR_NSEQ = 2'b10, TR_SEQ = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    PK_FIXED = 2'b00, PK_LAST = 2'b01, PK_LOWPWR = 2'b10, PK_LOWPWR_ALT = 2'b11
  } park_e;

  localparam logic [2:0] BU_INCR = 3'b001;

  // beats in a fixed-length burst; 1 for SINGLE and INCR
  function automatic logic [4:0] burst_beats(input logic [2:0] hb);
    case (hb[2:1])
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      2'b11:   return 5'd16;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
  parameter int unsigned NM = 4,
  parameter int unsigned PW = 2,
  parameter int unsigned IW = 2
) (
  input  logic [NM-1:0]         elig_i,
  input  logic [NM-1:0][PW-1:0] prio_i,
  input  logic                  own_valid_i,
  input  logic [IW-1:0]         own_idx_i,
  output logic                  win_valid_o,
  output logic [IW-1:0]         win_idx_o
);
  localparam int unsigned KW = PW + 1;

  logic [KW-1:0] best, key;

  // key = {prio, not_owner}; strict compare keeps lowest index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '1;
    key         = '1;
    for (int unsigned m = 0; m < NM; m++) begin
      if (elig_i[m]) begin
        key = {prio_i[m], ~(own_valid_i && (own_idx_i == IW'(m)))};
        if (!win_valid_o || key < best) begin
          best        = key;
          win_idx_o   = IW'(m);
          win_valid_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_arb_guard.sv
module xbar_arb_guard
  import xbar_arb_pkg::*;
#(
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned CW = $clog2(MAX_BEATS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chg_i,
  input  logic       acc_i,
  input  logic       act_i,
  input  logic [1:0] trans_i,
  input  logic [2:0] burst_i,
  input  logic       lock_i,
  input  logic       aulb_i,
  output logic       protect_o
);
  logic [CW-1:0] left_q;
  logic          fixed, lock_p, fix_p, incr_p;

  assign fixed = (burst_i[2:1] != 2'b00);

  // beats still owed after the last accepted beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   left_q <= '0;
    else if (chg_i)                                left_q <= '0;
    else if (acc_i && trans_i == TR_NSEQ)          left_q <= fixed ? CW'(burst_beats(burst_i) - 5'd1) : '0;
    else if (acc_i && trans_i == TR_SEQ && left_q != '0) left_q <= left_q - 1'b1;
  end

  always_comb begin
    lock_p = lock_i && (trans_i != TR_IDLE);
    fix_p  = fixed && ((trans_i == TR_NSEQ) ||
                       (trans_i == TR_SEQ  && left_q > CW'(1)) ||
                       (trans_i == TR_BUSY && left_q != '0));
    incr_p = aulb_i && (burst_i == BU_INCR) && (trans_i != TR_IDLE);
    protect_o = act_i && (lock_p || fix_p || incr_p);
  end

  a_r5_left_clears_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> (left_q == '0));
endmodule

// File: rtl/xbar_arb_owner.sv
module xbar_arb_owner
  import xbar_arb_pkg::*;
#(
  parameter int unsigned NM = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arb_en_i,
  input  logic          win_valid_i,
  input  logic [IW-1:0] win_idx_i,
  input  logic [1:0]    park_mode_i,
  input  logic [IW-1:0] park_id_i,
  input  logic [NM-1:0] req_i,
  input  logic [NM-1:0] pend_i,
  input  logic          acc_i,
  output logic          own_valid_o,
  output logic [IW-1:0] own_idx_o,
  output logic          fresh_o,
  output logic          chg_o
);
  logic          valid_q, fresh_q, nv;
  logic [IW-1:0] idx_q, ni;
  logic [NM-1:0] blk;

  assign blk = req_i & pend_i;

  always_comb begin
    nv = valid_q;
    ni = idx_q;
    if (arb_en_i) begin
      if (win_valid_i) begin
        nv = 1'b1;
        ni = win_idx_i;
      end else begin
        case (park_e'(park_mode_i))
          PK_FIXED: begin nv = !blk[park_id_i]; ni = park_id_i; end
          PK_LAST:  begin nv = valid_q && !blk[idx_q]; end
          default:  begin nv = 1'b0; ni = '0; end
        endcase
      end
    end
  end

  assign chg_o = (nv != valid_q) || (nv && ni != idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      valid_q <= nv;
      idx_q   <= ni;
      fresh_q <= chg_o ? nv : (fresh_q && !acc_i);
    end
  end

  assign own_valid_o = valid_q;
  assign own_idx_o   = idx_q;
  assign fresh_o     = fresh_q;
endmodule

// File: rtl/xbar_slave_arbiter.sv
module xbar_slave_arbiter
  import xbar_arb_pkg::*;
#(
  parameter int unsigned NM        = 4,
  parameter int unsigned PW        = 2,
  parameter int unsigned HW        = 4,
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NM-1:0]         sel_i,
  input  logic [NM-1:0][1:0]    htrans_i,
  input  logic [NM-1:0][2:0]    hburst_i,
  input  logic [NM-1:0]         hlock_i,
  input  logic [NM-1:0]         pend_i,
  input  logic [NM-1:0][PW-1:0] prio_i,
  input  logic [NM-1:0]         aulb_i,
  input  logic [1:0]            park_mode_i,
  input  logic [IW-1:0]         park_id_i,
  input  logic                  hready_i,
  output logic [NM-1:0]         grant_o,
  output logic [HW-1:0]         hmaster_o,
  output logic [1:0]            htrans_o,
  output logic [NM-1:0]         mready_o
);
  logic [NM-1:0] req_w, elig_w;
  logic          own_valid, fresh, chg, win_valid, protect, own_act, acc, arb_en;
  logic [IW-1:0] own_idx, win_idx;
  logic [1:0]    own_tr;

  for (genvar m = 0; m < NM; m++) begin : g_mst
    assign req_w[m]    = sel_i[m] && (htrans_i[m] != TR_IDLE);
    assign elig_w[m]   = req_w[m] && !pend_i[m];
    assign grant_o[m]  = own_valid && (own_idx == IW'(m));
    // non-owners: wait if active, local completion if idle
    assign mready_o[m] = grant_o[m] ? hready_i : !req_w[m];
  end

  assign own_act = own_valid && sel_i[own_idx];
  assign own_tr  = own_act ? htrans_i[own_idx] : TR_IDLE;
  assign acc     = hready_i && own_act && own_tr[1];
  assign arb_en  = hready_i && !protect;

  xbar_arb_pick #(.NM(NM), .PW(PW), .IW(IW)) i_pick (
    .elig_i(elig_w), .prio_i(prio_i), .own_valid_i(own_valid), .own_idx_i(own_idx),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  xbar_arb_guard #(.MAX_BEATS(MAX_BEATS)) i_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .chg_i(chg), .acc_i(acc), .act_i(own_act),
    .trans_i(own_tr), .burst_i(hburst_i[own_idx]), .lock_i(hlock_i[own_idx]),
    .aulb_i(aulb_i[own_idx]), .protect_o(protect)
  );

  xbar_arb_owner #(.NM(NM), .IW(IW)) i_owner (
    .clk_i(clk_i), .rst_ni(rst_ni), .arb_en_i(arb_en), .win_valid_i(win_valid),
    .win_idx_i(win_idx), .park_mode_i(park_mode_i), .park_id_i(park_id_i),
    .req_i(req_w), .pend_i(pend_i), .acc_i(acc),
    .own_valid_o(own_valid), .own_idx_o(own_idx), .fresh_o(fresh), .chg_o(chg)
  );

  assign htrans_o  = (fresh && own_tr == TR_SEQ) ? TR_NSEQ : own_tr;
  assign hmaster_o = own_valid ? HW'(own_idx) + HW'(1) : '0;

  a_r11_grant_hmaster: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((hmaster_o == '0) == (grant_o == '0)));
  a_r5_protected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect |=> $stable(grant_o));
  a_r2_no_pending_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~$past(grant_o) & $past(req_w & pend_i)) == '0);
  a_r8_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_w == '0) |-> (htrans_o == TR_IDLE));
  a_r10_lowpwr_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !protect && req_w == '0 && park_mode_i[1]) |=> (hmaster_o == '0));
  a_r1_wait_nonowner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_w & ~grant_o & mready_o) == '0);
endmodule

// File: tb/test_xbar_slave_arbiter.sv
module test_xbar_slave_arbiter;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]      sel, lk, pd, aulb, grant, mrdy;
  logic [3:0][1:0] ht, prio;
  logic [3:0][2:0] hb;
  logic [1:0]      pm, hto;
  logic [1:0]      pid;
  logic            hrdy;
  logic [3:0]      hmst;
  int checks = 0, errors = 0;
  bit done = 0;

  xbar_slave_arbiter i_xbar_slave_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .htrans_i(ht), .hburst_i(hb),
    .hlock_i(lk), .pend_i(pd), .prio_i(prio), .aulb_i(aulb), .park_mode_i(pm),
    .park_id_i(pid), .hready_i(hrdy), .grant_o(grant), .hmaster_o(hmst),
    .htrans_o(hto), .mready_o(mrdy)
  );

  typedef struct packed {
    logic [7:0]  ht; logic [11:0] hb; logic [3:0] lk; logic [3:0] pd;
    logic [3:0]  eg; logic [1:0]  eh;
  } vec_t;

  // ht/hb: master3..master0. prio m0=3 m1=2 m2=1 m3=0, park fixed on m0
  localparam vec_t VEC [22] = '{
    '{8'b00_00_00_00, 12'h000, 4'h0, 4'h0, 4'b0000, 2'b00}, // R8 R13 idle after reset
    '{8'b00_00_00_10, 12'h000, 4'h0, 4'h0, 4'b0001, 2'b10}, // R9 parked m0 goes at once
    '{8'b00_00_10_00, 12'h000, 4'h0, 4'h0, 4'b0001, 2'b00}, // R7 owner idle
    '{8'b00_10_10_00, 12'h000, 4'h0, 4'b0100, 4'b0010, 2'b10}, // R2 m2 pending
    '{8'b00_10_10_00, 12'h000, 4'h0, 4'h0, 4'b0010, 2'b10}, // R2 still m1
    '{8'b10_10_00_00, 12'h0C0, 4'h0, 4'h0, 4'b0100, 2'b10}, // R4 m2 preempted, INCR4 start
    '{8'b10_11_00_00, 12'h0C0, 4'h0, 4'h0, 4'b0100, 2'b11}, // R5
    '{8'b10_11_00_00, 12'h0C0, 4'h0, 4'h0, 4'b0100, 2'b11}, // R5
    '{8'b10_11_00_00, 12'h0C0, 4'h0, 4'h0, 4'b0100, 2'b11}, // R5 last beat
    '{8'b10_10_00_00, 12'h200, 4'h0, 4'h0, 4'b1000, 2'b10}, // R5 handover after burst
    '{8'b00_10_00_00, 12'h040, 4'h0, 4'h0, 4'b1000, 2'b00}, // R3 m3 idles
    '{8'b00_10_00_00, 12'h040, 4'h0, 4'h0, 4'b0100, 2'b10}, // R3
    '{8'b10_11_00_00, 12'h040, 4'h0, 4'h0, 4'b0100, 2'b11}, // R6 INCR, retain bit 0
    '{8'b10_11_00_00, 12'h040, 4'h0, 4'h0, 4'b1000, 2'b10}, // R6 preempted
    '{8'b00_11_00_00, 12'h040, 4'h0, 4'h0, 4'b1000, 2'b00}, // R3
    '{8'b00_11_00_00, 12'h040, 4'h0, 4'h0, 4'b0100, 2'b10}, // R12 SEQ shown as NONSEQ
    '{8'b00_11_00_00, 12'h040, 4'h0, 4'h0, 4'b0100, 2'b11}, // R12 then SEQ
    '{8'b10_10_00_00, 12'h000, 4'b0100, 4'h0, 4'b0100, 2'b10}, // R5 lock
    '{8'b10_10_00_00, 12'h000, 4'b0100, 4'h0, 4'b0100, 2'b10}, // R5 lock holds
    '{8'b10_00_00_00, 12'h000, 4'h0, 4'h0, 4'b0100, 2'b00}, // R3 release
    '{8'b00_00_00_00, 12'h000, 4'h0, 4'h0, 4'b1000, 2'b00}, // R8 no request
    '{8'b00_00_00_00, 12'h000, 4'h0, 4'h0, 4'b0001, 2'b00}  // R9 fixed park
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] hm_of(input logic [3:0] g);
    for (int m = 0; m < 4; m++) if (g[m]) return 4'(m + 1);
    return 4'd0;
  endfunction

  task automatic drive(input logic [3:0] s, input logic [7:0] t, input logic [11:0] b,
                       input logic [3:0] l, input logic [3:0] p);
    sel = s; ht = t; hb = b; lk = l; pd = p;
  endtask

  task automatic step_chk(input string tag, input logic [3:0] eg, input logic [1:0] eh);
    #5;
    chk({tag, " grant"}, 32'(grant), 32'(eg));
    chk({"R11 hmaster ", tag}, 32'(hmst), 32'(hm_of(eg)));
    chk({tag, " htrans"}, 32'(hto), 32'(eh));
  endtask

  initial begin
    drive(4'h0, 8'h00, 12'h000, 4'h0, 4'h0);
    prio = {2'd0, 2'd1, 2'd2, 2'd3};
    aulb = 4'h0; pm = 2'b00; pid = 2'd0; hrdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 reset grant", 32'(grant), 32'h0);
    chk("R13 reset hmaster", 32'(hmst), 32'h0);
    chk("R13 reset htrans", 32'(hto), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 22; k++) begin
      logic [3:0] s;
      for (int m = 0; m < 4; m++) s[m] = (VEC[k].ht[2*m +: 2] != 2'b00);
      drive(s, VEC[k].ht, VEC[k].hb, VEC[k].lk, VEC[k].pd);
      step_chk($sformatf("table v%0d", k), VEC[k].eg, VEC[k].eh);
      for (int m = 0; m < 4; m++)
        chk($sformatf("R1 R7 mready v%0d m%0d", k, m), 32'(mrdy[m]),
            32'(VEC[k].eg[m] ? hrdy : !s[m]));
      @(negedge clk);
    end
    // R6: retain bit set on m2, INCR burst keeps port
    aulb = 4'b0100;
    drive(4'b0100, 8'b00_10_00_00, 12'h040, 4'h0, 4'h0);
    step_chk("R1 parked elsewhere", 4'b0001, 2'b00);
    chk("R1 wait m2", 32'(mrdy[2]), 32'h0);
    @(negedge clk);
    step_chk("R6 start", 4'b0100, 2'b10);
    @(negedge clk);
    drive(4'b1100, 8'b10_11_00_00, 12'h040, 4'h0, 4'h0);
    step_chk("R6 beat", 4'b0100, 2'b11);
    @(negedge clk);
    step_chk("R6 retained", 4'b0100, 2'b11);
    chk("R1 wait m3", 32'(mrdy[3]), 32'h0);
    @(negedge clk);
    drive(4'b1000, 8'b10_00_00_00, 12'h000, 4'h0, 4'h0);
    step_chk("R3 m2 idles", 4'b0100, 2'b00);
    @(negedge clk);
    pm = 2'b01;
    drive(4'h0, 8'h00, 12'h000, 4'h0, 4'h0);
    step_chk("R9 last park in", 4'b1000, 2'b00);
    @(negedge clk);
    pm = 2'b10;
    step_chk("R9 last park kept", 4'b1000, 2'b00);
    @(negedge clk);
    step_chk("R10 low power", 4'b0000, 2'b00);
    @(negedge clk);
    drive(4'b0010, 8'b00_00_10_00, 12'h000, 4'h0, 4'h0);
    step_chk("R10 first request", 4'b0000, 2'b00);
    chk("R1 wait from low power", 32'(mrdy[1]), 32'h0);
    @(negedge clk);
    step_chk("R10 granted", 4'b0010, 2'b10);
    @(negedge clk);
    hrdy = 1'b0;
    drive(4'b1010, 8'b10_00_10_00, 12'h000, 4'h0, 4'h0);
    step_chk("R4 hready low", 4'b0010, 2'b10);
    chk("R1 owner sees hready", 32'(mrdy[1]), 32'h0);
    @(negedge clk);
    step_chk("R4 no change stalled", 4'b0010, 2'b10);
    @(negedge clk);
    hrdy = 1'b1;
    step_chk("R4 before preempt", 4'b0010, 2'b10);
    @(negedge clk);
    drive(4'b0010, 8'b10_00_10_00, 12'h000, 4'h0, 4'h0);
    step_chk("R3 owner leaves port", 4'b1000, 2'b00);
    @(negedge clk);
    prio[0] = 2'd2;
    drive(4'b0011, 8'b00_00_10_00, 12'h000, 4'h0, 4'h0);
    step_chk("R7 idle check", 4'b0010, 2'b10);
    chk("R7 local idle m0", 32'(mrdy[0]), 32'h1);
    @(negedge clk);
    drive(4'b0011, 8'b00_00_10_10, 12'h000, 4'h0, 4'h0);
    step_chk("R4 tie", 4'b0010, 2'b10);
    @(negedge clk);
    step_chk("R4 tie keeps owner", 4'b0010, 2'b10);
    @(negedge clk);
    prio[2] = 2'd2;
    drive(4'b0101, 8'b00_10_00_10, 12'h000, 4'h0, 4'h0);
    step_chk("R4 tie index", 4'b0010, 2'b00);
    @(negedge clk);
    step_chk("R4 lower index wins", 4'b0001, 2'b10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule